// File: doc/BRIEF.md
# Tiled Surface Byte-Address Generator

This unit maps an integer texel coordinate (x, y and, for volumes, z) to a byte offset inside a surface whose memory layout is tiled. Each request carries the surface description alongside the coordinate: a two-axis base offset, the bytes per texel, the row pitch, horizontal and vertical slice pitches, three tile shift amounts and two swizzle shift amounts. Choosing these values selects the tiling layout. Row-major tiles are described directly. Column-major tiles are described as a row of narrow row-major tiles placed side by side.

A volume slice index is split into a minor part, which moves the texel horizontally, and a major part, which moves it vertically. An optional bit-6 swizzle then XORs bit 6 of the address with bit 6 of two right-shifted copies of that address. Linear one-axis surfaces skip tiling and swizzling. The result is registered, so it appears one cycle after the request, with no back-pressure.

Top module: `tsa_addr_gen`

## Requirements
- R1: The base offsets are added to x and y before any other step. A coordinate beyond the surface dimensionality counts as zero: y is ignored when `dims` is 0 or 1, and z is ignored unless `dims` is 3.
- R2: When `dims` is 3, z is split at `tile_sh_z`. The low `tile_sh_z` bits are multiplied by `slice_pitch_h` and added to x. z shifted right by `tile_sh_z` is multiplied by `slice_pitch_v` and added to y.
- R3: When `dims` is 2 or 3, each axis is split at its tile shift. The minor index is the low bits of the coordinate. The major index is the coordinate shifted right by the tile shift.
- R4: In the tiled case, the texel index is `(((major_x << sh_y) + minor_y) << sh_x) + minor_x + (major_y << sh_y) * row_pitch`. The byte address is this texel index times `texel_bytes`.
- R5: When `dims` is 0 or 1, the byte address is `(x + y * row_pitch) * texel_bytes`, with no tiling and no swizzle. Here y is `base_y`.
- R6: The swizzle applies in the tiled case when `swz_en` is 1. It changes only bit 6: that bit is XORed with bit 6 of `(addr >> a) ^ (addr >> b)`. Only the low 5 bits of each swizzle amount are used, so 0xFF acts as 31.
- R7: When `swz_en` is 0, the swizzle stage is bypassed and the address is left unchanged.
- R8: A tile shift of 32 or more makes a right or left shift return zero, and makes the minor index the whole coordinate.
- R9: `out_valid` is `in_valid` delayed by one cycle. `out_addr` loads only on a cycle where `in_valid` is 1 and holds otherwise. Reset clears both.
- R10: All arithmetic is 32-bit unsigned and wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| dims | input | 2 | Coordinate count: 0/1 = linear, 2 = planar, 3 = volume |
| coord_x | input | 32 | Texel x |
| coord_y | input | 32 | Texel y |
| coord_z | input | 32 | Texel z / slice |
| base_x | input | 32 | Surface x offset |
| base_y | input | 32 | Surface y offset |
| texel_bytes | input | 32 | Bytes per texel |
| row_pitch | input | 32 | Texels per tile row |
| slice_pitch_h | input | 32 | Horizontal slice pitch |
| slice_pitch_v | input | 32 | Vertical slice pitch |
| tile_sh_x | input | 8 | Tile shift along x |
| tile_sh_y | input | 8 | Tile shift along y |
| tile_sh_z | input | 8 | Slice split shift |
| swz_sh_a | input | 8 | First swizzle shift |
| swz_sh_b | input | 8 | Second swizzle shift |
| swz_en | input | 1 | Swizzle stage enable |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 32 | Byte offset |

## Verification
The two functions that can fall in the same cycle are the volume slice placement and the bit-6 swizzle. A volume request with nonzero slice pitches moves the tiled address through the slice offset before the swizzle reads it back. The bench provokes this with volume vectors that have both swizzle shifts active, then repeats the same vectors with the swizzle disabled. Each result is judged against an independent model of the full chain. Hand-computed vectors pin down the bypass and 0xFF cases.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int AW  = 32;
  localparam int SHW = 8;
  localparam int SWZ_BIT = 6;
  localparam int LAW = $clog2(AW);

  typedef logic [AW-1:0]  word_t;
  typedef logic [SHW-1:0] sh_t;

  function automatic word_t shr_sat(word_t v, sh_t s);
    return (int'(s) >= AW) ? '0 : (v >> s);
  endfunction

  function automatic word_t shl_sat(word_t v, sh_t s);
    return (int'(s) >= AW) ? '0 : (v << s);
  endfunction

  function automatic word_t low_part(word_t v, sh_t s);
    return (int'(s) >= AW) ? v : (v & ~({AW{1'b1}} << s));
  endfunction
endpackage

// File: rtl/tsa_coord_prep.sv
module tsa_coord_prep
  import tsa_pkg::*;
(
  input  logic [1:0] dims,
  input  word_t      coord_x,
  input  word_t      coord_y,
  input  word_t      coord_z,
  input  word_t      base_x,
  input  word_t      base_y,
  input  word_t      slice_pitch_h,
  input  word_t      slice_pitch_v,
  input  sh_t        tile_sh_z,
  output word_t      pos_x,
  output word_t      pos_y
);
  word_t y_in, z_in, ofs_x, ofs_y, z_lo, z_hi;

  always_comb begin
    y_in  = (dims >= 2'd2) ? coord_y : '0;
    z_in  = (dims == 2'd3) ? coord_z : '0;
    ofs_x = base_x + coord_x;
    ofs_y = base_y + y_in;
    z_lo  = low_part(z_in, tile_sh_z);
    z_hi  = shr_sat(z_in, tile_sh_z);
    if (dims == 2'd3) begin
      pos_x = ofs_x + z_lo * slice_pitch_h;
      pos_y = ofs_y + z_hi * slice_pitch_v;
    end else begin
      pos_x = ofs_x;
      pos_y = ofs_y;
    end
  end
endmodule

// File: rtl/tsa_tile_index.sv
module tsa_tile_index
  import tsa_pkg::*;
(
  input  logic  tiled,
  input  word_t pos_x,
  input  word_t pos_y,
  input  sh_t   tile_sh_x,
  input  sh_t   tile_sh_y,
  input  word_t row_pitch,
  input  word_t texel_bytes,
  output word_t byte_addr
);
  word_t mn_x, mn_y, mj_x, mj_y, span, row_base, texel;

  always_comb begin
    mn_x     = low_part(pos_x, tile_sh_x);
    mn_y     = low_part(pos_y, tile_sh_y);
    mj_x     = shr_sat(pos_x, tile_sh_x);
    mj_y     = shr_sat(pos_y, tile_sh_y);
    span     = shl_sat(shl_sat(mj_x, tile_sh_y) + mn_y, tile_sh_x) + mn_x;
    row_base = shl_sat(mj_y, tile_sh_y);
    if (tiled) texel = span + row_base * row_pitch;
    else       texel = pos_x + pos_y * row_pitch;
    byte_addr = texel * texel_bytes;
  end
endmodule

// File: rtl/tsa_bit_swizzle.sv
module tsa_bit_swizzle
  import tsa_pkg::*;
#(
  parameter int FLIP_BIT = SWZ_BIT
) (
  input  logic  enable,
  input  word_t addr_i,
  input  sh_t   amt_a,
  input  sh_t   amt_b,
  output word_t addr_o
);
  word_t mix;

  always_comb begin
    mix = (addr_i >> amt_a[LAW-1:0]) ^ (addr_i >> amt_b[LAW-1:0]);
    addr_o = addr_i;
    if (enable) addr_o[FLIP_BIT] = addr_i[FLIP_BIT] ^ mix[FLIP_BIT];
  end
endmodule

// File: rtl/tsa_addr_gen.sv
module tsa_addr_gen
  import tsa_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  dims,
  input  logic [31:0] coord_x,
  input  logic [31:0] coord_y,
  input  logic [31:0] coord_z,
  input  logic [31:0] base_x,
  input  logic [31:0] base_y,
  input  logic [31:0] texel_bytes,
  input  logic [31:0] row_pitch,
  input  logic [31:0] slice_pitch_h,
  input  logic [31:0] slice_pitch_v,
  input  logic [7:0]  tile_sh_x,
  input  logic [7:0]  tile_sh_y,
  input  logic [7:0]  tile_sh_z,
  input  logic [7:0]  swz_sh_a,
  input  logic [7:0]  swz_sh_b,
  input  logic        swz_en,
  output logic        out_valid,
  output logic [31:0] out_addr
);
  word_t pos_x, pos_y, raw_addr, swz_addr;
  logic  tiled;
  word_t addr_d;
  logic  valid_d;

  assign tiled = (dims >= 2'd2);

  tsa_coord_prep u_prep (
    .dims(dims), .coord_x(coord_x), .coord_y(coord_y), .coord_z(coord_z),
    .base_x(base_x), .base_y(base_y), .slice_pitch_h(slice_pitch_h),
    .slice_pitch_v(slice_pitch_v), .tile_sh_z(tile_sh_z),
    .pos_x(pos_x), .pos_y(pos_y)
  );

  tsa_tile_index u_index (
    .tiled(tiled), .pos_x(pos_x), .pos_y(pos_y), .tile_sh_x(tile_sh_x),
    .tile_sh_y(tile_sh_y), .row_pitch(row_pitch), .texel_bytes(texel_bytes),
    .byte_addr(raw_addr)
  );

  tsa_bit_swizzle #(.FLIP_BIT(SWZ_BIT)) u_swz (
    .enable(swz_en && tiled), .addr_i(raw_addr), .amt_a(swz_sh_a),
    .amt_b(swz_sh_b), .addr_o(swz_addr)
  );

  always_comb begin
    valid_d = in_valid;
    addr_d  = in_valid ? swz_addr : out_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= valid_d;
      out_addr  <= addr_d;
    end
  end

  // Swizzle may touch bit 6 only (R6)
  p_only_bit6_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((swz_addr ^ raw_addr) & ~(word_t'(1) << SWZ_BIT)) == '0);

  // Disabled swizzle leaves the address alone (R7)
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !swz_en |-> swz_addr == raw_addr);

  // Result strobe follows the request by one cycle (R9)
  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // Address holds without a request (R9)
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_addr));
endmodule

// File: tb/tsa_addr_gen_tb.sv
module tsa_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  dims;
  logic [31:0] coord_x, coord_y, coord_z, base_x, base_y;
  logic [31:0] texel_bytes, row_pitch, slice_pitch_h, slice_pitch_v;
  logic [7:0]  tile_sh_x, tile_sh_y, tile_sh_z, swz_sh_a, swz_sh_b;
  logic        swz_en;
  logic        out_valid;
  logic [31:0] out_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tsa_addr_gen dut_i (.*);

  typedef struct packed {
    logic [1:0]  d;
    logic [31:0] x, y, z, bx, by, bpp, pitch, sh, sv;
    logic [7:0]  tx, ty, tz, sa, sb;
    logic        en;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 32'd37,  32'd11, 32'd0,  32'd0,  32'd0,  32'd4,  32'd16,  32'd0,   32'd0,   8'd7, 8'd3, 8'd0, 8'd3,  8'd4,  1'b1},
    '{2'd2, 32'd100, 32'd45, 32'd0,  32'd8,  32'd2,  32'd4,  32'd8,   32'd0,   32'd0,   8'd2, 8'd5, 8'd0, 8'd3,  8'hFF, 1'b1},
    '{2'd3, 32'd5,   32'd9,  32'd13, 32'd0,  32'd0,  32'd4,  32'd32,  32'd64,  32'd128, 8'd4, 8'd3, 8'd2, 8'd3,  8'd4,  1'b1},
    '{2'd3, 32'd5,   32'd9,  32'd13, 32'd0,  32'd0,  32'd4,  32'd32,  32'd64,  32'd128, 8'd4, 8'd3, 8'd2, 8'd3,  8'd4,  1'b0},
    '{2'd3, 32'd77,  32'd3,  32'd30, 32'd16, 32'd1,  32'd8,  32'd16,  32'd200, 32'd40,  8'd5, 8'd2, 8'd3, 8'd5,  8'd2,  1'b1},
    '{2'd2, 32'd9,   32'd5,  32'd99, 32'd0,  32'd0,  32'd2,  32'd64,  32'd7,   32'd7,   8'd40,8'd3, 8'd1, 8'hFF, 8'hFF, 1'b1},
    '{2'd1, 32'd21,  32'd50, 32'd50, 32'd3,  32'd4,  32'd4,  32'd100, 32'd9,   32'd9,   8'd3, 8'd3, 8'd3, 8'd0,  8'd1,  1'b1},
    '{2'd3, 32'hFFFF0000, 32'h7FFF, 32'd6, 32'h1000, 32'd1, 32'd16, 32'h10001, 32'h20000, 32'h30000, 8'd3, 8'd4, 8'd1, 8'd1, 8'd9, 1'b1}
  };

  function automatic logic [31:0] sr(logic [31:0] v, logic [7:0] s);
    if (s > 8'd31) return 32'd0;
    return v >> s;
  endfunction
  function automatic logic [31:0] sl(logic [31:0] v, logic [7:0] s);
    if (s > 8'd31) return 32'd0;
    return v << s;
  endfunction
  function automatic logic [31:0] lo(logic [31:0] v, logic [7:0] s);
    if (s > 8'd31) return v;
    return v - ((v >> s) << s);
  endfunction

  // Independent model of R1..R8, R10
  function automatic logic [31:0] model(vec_t v);
    logic [31:0] px, py, zz, t, a, m;
    px = v.bx + v.x;
    py = v.by + ((v.d >= 2) ? v.y : 32'd0);
    if (v.d == 3) begin
      zz = v.z;
      px = px + lo(zz, v.tz) * v.sh;
      py = py + sr(zz, v.tz) * v.sv;
    end
    if (v.d < 2) return (px + py * v.pitch) * v.bpp;
    t = sl(sl(sr(px, v.tx), v.ty) + lo(py, v.ty), v.tx) + lo(px, v.tx)
        + sl(sr(py, v.ty), v.ty) * v.pitch;
    a = t * v.bpp;
    if (v.en) begin
      m = (a >> v.sa[4:0]) ^ (a >> v.sb[4:0]);
      a = a ^ (m & 32'h40);
    end
    return a;
  endfunction

  task automatic drive(vec_t v);
    @(negedge clk);
    dims = v.d; coord_x = v.x; coord_y = v.y; coord_z = v.z;
    base_x = v.bx; base_y = v.by; texel_bytes = v.bpp; row_pitch = v.pitch;
    slice_pitch_h = v.sh; slice_pitch_v = v.sv; tile_sh_x = v.tx;
    tile_sh_y = v.ty; tile_sh_z = v.tz; swz_sh_a = v.sa; swz_sh_b = v.sb;
    swz_en = v.en; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic vec_t mk(logic [1:0] d, logic [31:0] x, logic [31:0] y,
                              logic [31:0] bx, logic [31:0] by, logic [31:0] bpp,
                              logic [31:0] pitch, logic [7:0] tx, logic [7:0] ty,
                              logic [7:0] sa, logic [7:0] sb, logic en);
    vec_t v;
    v = '0;
    v.d = d; v.x = x; v.y = y; v.bx = bx; v.by = by; v.bpp = bpp;
    v.pitch = pitch; v.tx = tx; v.ty = ty; v.sa = sa; v.sb = sb; v.en = en;
    v.z = 32'd77; v.sh = 32'd5; v.sv = 32'd5;
    return v;
  endfunction

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; dims = '0; coord_x = '0; coord_y = '0;
    coord_z = '0; base_x = '0; base_y = '0; texel_bytes = '0; row_pitch = '0;
    slice_pitch_h = '0; slice_pitch_v = '0; tile_sh_x = '0; tile_sh_y = '0;
    tile_sh_z = '0; swz_sh_a = '0; swz_sh_b = '0; swz_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {31'd0, out_valid}, 32'd0);
    check("R9 reset addr", out_addr, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      check("R1-model R2 R3 R4 R6", out_addr, model(VECS[i]));
      check("R9 valid high", {31'd0, out_valid}, 32'd1);
    end

    // R5: linear, y input ignored: (1+3 + 2*100)*4 = 816
    drive(mk(2'd1, 32'd3, 32'd999, 32'd1, 32'd2, 32'd4, 32'd100, 8'd2, 8'd2, 8'd0, 8'd1, 1'b1));
    check("R5 R1 linear", out_addr, 32'd816);

    // R6: no tiling, x=16 bpp=4 -> 64; a=0, b=0xFF(31) flips bit 6 -> 0
    drive(mk(2'd2, 32'd16, 32'd0, 32'd0, 32'd0, 32'd4, 32'd8, 8'd0, 8'd0, 8'd0, 8'hFF, 1'b1));
    check("R6 swizzle flip", out_addr, 32'd0);

    // R7: same request with swizzle disabled -> 64
    drive(mk(2'd2, 32'd16, 32'd0, 32'd0, 32'd0, 32'd4, 32'd8, 8'd0, 8'd0, 8'd0, 8'hFF, 1'b0));
    check("R7 bypass", out_addr, 32'd64);

    // R6: both 0xFF -> no change (64)
    drive(mk(2'd2, 32'd16, 32'd0, 32'd0, 32'd0, 32'd4, 32'd8, 8'd0, 8'd0, 8'hFF, 8'hFF, 1'b1));
    check("R6 both 0xFF", out_addr, 32'd64);

    // R8: tile_sh_x=40 -> minor x = 5, majors zero, y=3 ty=4 -> minor_y<<40 = 0; addr 5*2=10
    drive(mk(2'd2, 32'd5, 32'd3, 32'd0, 32'd0, 32'd2, 32'd8, 8'd40, 8'd4, 8'hFF, 8'hFF, 1'b1));
    check("R8 wide shift", out_addr, 32'd10);

    // R10: linear wrap, 0x80000000*2 = 0
    drive(mk(2'd0, 32'h8000_0000, 32'd0, 32'd0, 32'd0, 32'd2, 32'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0));
    check("R10 wrap", out_addr, 32'd0);

    // R9: idle cycles, output holds and strobe low
    coord_x = 32'd1234; dims = 2'd1; texel_bytes = 32'd1;
    repeat (2) @(negedge clk);
    check("R9 hold addr", out_addr, 32'd0);
    check("R9 valid low", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule